// File: doc/BRIEF.md
# Level-Shifted Carrier Modulator for a Six-Cell Converter Arm

This block drives the switches of one arm of a modular multilevel converter whose arm holds six half-bridge cells. Every slower time base comes from dividing a single fast system clock. The time bases are a triangular carrier, a stepped sinusoidal reference and a slow rotation timer.

The block stacks six copies of the carrier, all in phase, into six adjacent bands that span the reference range. It compares the reference against every band. A cell is inserted when the reference lies above the band that the cell currently owns. Stacking six bands this way gives seven possible arm voltage levels.

Ownership of the bands moves one cell along at a slow, fixed rate. Over time every cell spends equal time on every band, so the cell capacitors share the work without any voltage feedback. Each cell gets an upper and a lower gate line. A turn-on on either line is always preceded by a guaranteed interval in which both lines are off. The block also reports how many cells the modulator currently inserts.

Top module: `lspwm_arm`

## Requirements
- R1: While reset is active or `en` is low, every gate line is 0, `ins_cnt` is 0 and the rotation index is 0. After `en` rises with `mod_idx` = 0, the first settled upper-gate pattern is therefore 6'b000111: cells 0, 1 and 2 are inserted.
- R2: The carrier counter `c` runs up and down between 0 and 2^CW-1 and moves one step every CAR_DIV cycles. Band k (k = 0..5) has the value k*2^CW + c. With `mod_idx` = 0 the reference sits at mid-range, HALF = 3*2^CW, so `ins_cnt` stays at exactly 3. `ins_cnt` never exceeds 6.
- R3: The reference is computed as follows.
  - The phase p is 8 bits wide and advances every PH_DIV cycles.
  - Let x = p[5:0] when p[6] = 0, and x = 64 - p[5:0] otherwise.
  - Let s = floor(x*(128-x)*HALF*mod_idx / (4096*255)).
  - The reference is HALF+s when p[7] = 0 and HALF-s when p[7] = 1.
  - With `mod_idx` = 255 the reference reaches the top and bottom of the range, so over one fundamental period `ins_cnt` reaches both 6 and 0.
- R4: `ins_cnt` equals the number of bands strictly below the reference. With CW = 4, the minimum and maximum of `ins_cnt` over a full period are 2..4 for `mod_idx` = 64, 1..5 for 128 and 0..6 for 200.
- R5: Cell i is inserted (`gate_up[i]`=1, `gate_dn[i]`=0) when its band is below the reference; otherwise it is bypassed (`gate_up[i]`=0, `gate_dn[i]`=1). Once settled, the number of set bits of `gate_up` equals `ins_cnt`.
- R6: `gate_up[i]` and `gate_dn[i]` are never 1 in the same cycle.
- R7: Before either gate line of a cell turns on, both lines of that cell have been 0 for at least DT_CYC cycles. This also holds for the first turn-on after `en` rises.
- R8: Cell i owns band (i + r) mod 6, where r is the rotation index. r only steps from its old value to old+1 mod 6. With `mod_idx` = 0 the settled upper pattern after n rotations has bit i set iff (i+n) mod 6 < 3.
- R9: The rotation index advances only when the carrier leaves 0. The timer that allows a rotation restarts at each rotation and allows the next one after ROT_DIV cycles. Consecutive rotations are therefore spaced by ceil(ROT_DIV/P)*P cycles, where P = 2*(2^CW-1)*CAR_DIV is the carrier period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low returns all state to idle |
| mod_idx | input | MW | Modulation index, 255 = full scale |
| gate_up | output | NSM | Upper switch gate per cell |
| gate_dn | output | NSM | Lower switch gate per cell |
| ins_cnt | output | clog2(NSM+1) | Number of cells the modulator inserts |

## Verification
With a zero index the reference sits exactly on a band boundary. If the band offset or the strict comparison were wrong, the count would drift from 3, and a cell mapping in the wrong direction would rotate the gate pattern left instead of right. The bench sweeps several indices across a whole fundamental period and compares the extreme counts. A scaling or sign error in the reference would move those extremes, and a band stacked out of place would leave 6 or 0 unreachable. Rotations that fire off the carrier valley, or whose timer does not restart, show up as wrong spacing between pattern changes. Shortened or missing dead time shows up as overlap, or as a turn-on that arrives too early after the opposite line falls, including right after `en` rises and after a disable with the rotation index not cleared.

// File: rtl/lspwm_pkg.sv
package lspwm_pkg;

    typedef enum logic [1:0] {
        LEG_OFF = 2'd0,
        LEG_UP  = 2'd1,
        LEG_DN  = 2'd2
    } leg_e;

    function automatic int cw(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lspwm_timebase.sv
module lspwm_timebase #(
    parameter int CW      = 10,
    parameter int PW      = 8,
    parameter int NSM     = 6,
    parameter int CAR_DIV = 326,
    parameter int PH_DIV  = 7812,
    parameter int ROT_DIV = 4000000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    output logic [CW-1:0]                car_o,
    output logic [PW-1:0]                ph_o,
    output logic [lspwm_pkg::cw(NSM)-1:0] rot_o
);
    localparam int CDW  = lspwm_pkg::cw(CAR_DIV);
    localparam int PDW  = lspwm_pkg::cw(PH_DIV);
    localparam int RDW  = lspwm_pkg::cw(ROT_DIV);
    localparam int RIW  = lspwm_pkg::cw(NSM);
    localparam int CMAX = (2 ** CW) - 1;

    typedef struct packed {
        logic [CW-1:0]  car;
        logic           up;
        logic [CDW-1:0] cdiv;
        logic [PW-1:0]  ph;
        logic [PDW-1:0] pdiv;
        logic [RIW-1:0] rot;
        logic [RDW-1:0] rdiv;
        logic           pend;
    } tb_st_t;

    function automatic tb_st_t idle_st();
        tb_st_t s;
        s    = '0;
        s.up = 1'b1;
        return s;
    endfunction

    tb_st_t s_q, s_d;
    logic   step, pstep, valley;

    always_comb begin
        s_d    = s_q;
        step   = (s_q.cdiv == CDW'(CAR_DIV - 1));
        pstep  = (s_q.pdiv == PDW'(PH_DIV - 1));
        valley = step && (s_q.car == '0);

        // carrier divider and up/down count
        if (step) begin
            s_d.cdiv = '0;
            if (s_q.up) begin
                if (s_q.car == CW'(CMAX)) begin
                    s_d.up  = 1'b0;
                    s_d.car = CW'(CMAX - 1);
                end else begin
                    s_d.car = s_q.car + 1'b1;
                end
            end else begin
                if (s_q.car == '0) begin
                    s_d.up  = 1'b1;
                    s_d.car = CW'(1);
                end else begin
                    s_d.car = s_q.car - 1'b1;
                end
            end
        end else begin
            s_d.cdiv = s_q.cdiv + 1'b1;
        end

        // reference phase
        if (pstep) begin
            s_d.pdiv = '0;
            s_d.ph   = s_q.ph + 1'b1;
        end else begin
            s_d.pdiv = s_q.pdiv + 1'b1;
        end

        // rotation: timer arms a request, the valley applies it
        if (s_q.pend) begin
            s_d.rdiv = '0;
            if (valley) begin
                s_d.pend = 1'b0;
                s_d.rot  = (s_q.rot == RIW'(NSM - 1)) ? '0 : s_q.rot + 1'b1;
            end
        end else if (s_q.rdiv == RDW'(ROT_DIV - 1)) begin
            s_d.rdiv = '0;
            s_d.pend = 1'b1;
        end else begin
            s_d.rdiv = s_q.rdiv + 1'b1;
        end

        if (!en) begin
            s_d = idle_st();
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= idle_st();
        end else begin
            s_q <= s_d;
        end
    end

    assign car_o = s_q.car;
    assign ph_o  = s_q.ph;
    assign rot_o = s_q.rot;

endmodule

// File: rtl/lspwm_reference.sv
module lspwm_reference #(
    parameter int CW  = 10,
    parameter int PW  = 8,
    parameter int MW  = 8,
    parameter int NSM = 6,
    parameter int RW  = 13
) (
    input  logic [PW-1:0] ph,
    input  logic [MW-1:0] mod_idx,
    output logic [RW-1:0] ref_o
);
    localparam int Q     = 2 ** (PW - 2);
    localparam int XW    = PW - 1;
    localparam int HALF  = (NSM * (2 ** CW)) / 2;
    localparam int MFULL = (2 ** MW) - 1;
    localparam int DIVC  = Q * Q * MFULL;
    localparam int PRW   = 2 * PW + RW + MW;

    logic [PW-3:0]  idx;
    logic [XW-1:0]  x;
    logic [PRW-1:0] shape, prod, scaled;
    logic           neg;

    always_comb begin
        idx    = ph[PW-3:0];
        neg    = ph[PW-1];
        x      = ph[PW-2] ? (XW'(Q) - {1'b0, idx}) : {1'b0, idx};
        // parabolic quarter-wave, peak Q*Q at x = Q
        shape  = PRW'(x) * (PRW'(2 * Q) - PRW'(x));
        prod   = shape * PRW'(HALF) * PRW'(mod_idx);
        scaled = prod / PRW'(DIVC);
        ref_o  = neg ? (RW'(HALF) - RW'(scaled)) : (RW'(HALF) + RW'(scaled));
    end

endmodule

// File: rtl/lspwm_compare.sv
module lspwm_compare #(
    parameter int CW  = 10,
    parameter int NSM = 6,
    parameter int RW  = 13
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  logic [CW-1:0]                 car,
    input  logic [RW-1:0]                 ref_lvl,
    input  logic [lspwm_pkg::cw(NSM)-1:0] rot,
    output logic [NSM-1:0]                want_o,
    output logic [$clog2(NSM+1)-1:0]      cnt_o
);
    localparam int RIW  = lspwm_pkg::cw(NSM);
    localparam int CNTW = $clog2(NSM + 1);

    typedef struct packed {
        logic [NSM-1:0]  want;
        logic [CNTW-1:0] cnt;
    } cmp_st_t;

    cmp_st_t        s_q, s_d;
    logic [NSM-1:0] below;
    logic [RIW-1:0] jj;

    always_comb begin
        s_d   = '0;
        below = '0;
        jj    = '0;
        for (int k = 0; k < NSM; k++) begin
            below[k] = ref_lvl > ((RW'(k) << CW) | RW'(car));
            s_d.cnt  = s_d.cnt + CNTW'(below[k]);
        end
        for (int i = 0; i < NSM; i++) begin
            int j;
            j = i + int'(rot);
            if (j >= NSM) begin
                j = j - NSM;
            end
            jj          = RIW'(j);
            s_d.want[i] = below[jj];
        end
        if (!en) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign want_o = s_q.want;
    assign cnt_o  = s_q.cnt;

endmodule

// File: rtl/lspwm_deadtime.sv
module lspwm_deadtime #(
    parameter int DT_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic want,
    output logic up_o,
    output logic dn_o
);
    import lspwm_pkg::*;

    localparam int DTW = lspwm_pkg::cw(DT_CYC + 1);

    typedef struct packed {
        leg_e           st;
        logic [DTW-1:0] cnt;
    } dt_st_t;

    dt_st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            LEG_UP: begin
                if (!want) begin
                    s_d.st  = LEG_OFF;
                    s_d.cnt = '0;
                end
            end
            LEG_DN: begin
                if (want) begin
                    s_d.st  = LEG_OFF;
                    s_d.cnt = '0;
                end
            end
            default: begin
                if (s_q.cnt == DTW'(DT_CYC - 1)) begin
                    s_d.st = want ? LEG_UP : LEG_DN;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        endcase
        if (!en) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign up_o = (s_q.st == LEG_UP);
    assign dn_o = (s_q.st == LEG_DN);

endmodule

// File: rtl/lspwm_arm.sv
module lspwm_arm #(
    parameter int NSM     = 6,
    parameter int CW      = 10,
    parameter int PW      = 8,
    parameter int MW      = 8,
    parameter int CAR_DIV = 326,
    parameter int PH_DIV  = 7812,
    parameter int ROT_DIV = 4000000,
    parameter int DT_CYC  = 20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [MW-1:0]            mod_idx,
    output logic [NSM-1:0]           gate_up,
    output logic [NSM-1:0]           gate_dn,
    output logic [$clog2(NSM+1)-1:0] ins_cnt
);
    localparam int RIW  = lspwm_pkg::cw(NSM);
    localparam int CNTW = $clog2(NSM + 1);
    localparam int RW   = $clog2(NSM * (2 ** CW) + 1);

    logic [CW-1:0]  car;
    logic [PW-1:0]  ph;
    logic [RIW-1:0] rot_idx;
    logic [RW-1:0]  ref_lvl;
    logic [NSM-1:0] want;

    lspwm_timebase #(
        .CW(CW), .PW(PW), .NSM(NSM),
        .CAR_DIV(CAR_DIV), .PH_DIV(PH_DIV), .ROT_DIV(ROT_DIV)
    ) u_tb (
        .clk(clk), .rst_n(rst_n), .en(en),
        .car_o(car), .ph_o(ph), .rot_o(rot_idx)
    );

    lspwm_reference #(
        .CW(CW), .PW(PW), .MW(MW), .NSM(NSM), .RW(RW)
    ) u_ref (
        .ph(ph), .mod_idx(mod_idx), .ref_o(ref_lvl)
    );

    lspwm_compare #(
        .CW(CW), .NSM(NSM), .RW(RW)
    ) u_cmp (
        .clk(clk), .rst_n(rst_n), .en(en),
        .car(car), .ref_lvl(ref_lvl), .rot(rot_idx),
        .want_o(want), .cnt_o(ins_cnt)
    );

    for (genvar gi = 0; gi < NSM; gi++) begin : g_leg
        lspwm_deadtime #(
            .DT_CYC(DT_CYC)
        ) u_dt (
            .clk(clk), .rst_n(rst_n), .en(en),
            .want(want[gi]),
            .up_o(gate_up[gi]), .dn_o(gate_dn[gi])
        );
    end

endmodule

// File: rtl/lspwm_arm_chk.sv
module lspwm_arm_chk #(
    parameter int NSM    = 6,
    parameter int DT_CYC = 20,
    parameter int RIW    = 3,
    parameter int CNTW   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            en,
    input logic [NSM-1:0]  gate_up,
    input logic [NSM-1:0]  gate_dn,
    input logic [CNTW-1:0] ins_cnt,
    input logic [RIW-1:0]  rot_idx
);
    localparam int OW = lspwm_pkg::cw(DT_CYC + 2);
    localparam logic [OW-1:0]   DT_L  = OW'(DT_CYC);
    localparam logic [CNTW-1:0] NSM_L = CNTW'(NSM);
    localparam logic [RIW-1:0]  TOP_R = RIW'(NSM - 1);

    // R6
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_up & gate_dn) == '0);

    // R2
    a_r2_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        ins_cnt <= NSM_L);

    // R1
    a_r1_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (gate_up == '0 && gate_dn == '0 && ins_cnt == '0 && rot_idx == '0));

    // R8
    a_r8_rot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && rot_idx != $past(rot_idx)) |->
        (rot_idx == (($past(rot_idx) == TOP_R) ? '0 : $past(rot_idx) + 1'b1)));

    for (genvar gi = 0; gi < NSM; gi++) begin : g_dt
        logic [OW-1:0] off_run;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                off_run <= '0;
            end else if (gate_up[gi] || gate_dn[gi]) begin
                off_run <= '0;
            end else if (off_run != {OW{1'b1}}) begin
                off_run <= off_run + 1'b1;
            end
        end

        // R7
        a_r7_dead_up: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_up[gi]) |-> (off_run >= DT_L));
        a_r7_dead_dn: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_dn[gi]) |-> (off_run >= DT_L));
    end

endmodule

bind lspwm_arm lspwm_arm_chk #(
    .NSM(NSM), .DT_CYC(DT_CYC), .RIW(RIW), .CNTW(CNTW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en),
    .gate_up(gate_up), .gate_dn(gate_dn),
    .ins_cnt(ins_cnt), .rot_idx(rot_idx)
);

// File: tb/sim_lspwm_arm.sv
module sim_lspwm_arm;
    localparam int NSM     = 6;
    localparam int CW      = 4;
    localparam int CAR_DIV = 8;
    localparam int PH_DIV  = 32;
    localparam int ROT_DIV = 1000;
    localparam int DT      = 4;
    localparam int PERIOD  = 2 * ((2 ** CW) - 1) * CAR_DIV;
    localparam int ROT_GAP = ((ROT_DIV + PERIOD - 1) / PERIOD) * PERIOD;
    localparam int FUND    = 256 * PH_DIV;
    localparam int NV      = 5;
    localparam int VM   [NV] = '{0, 64, 128, 200, 255};
    localparam int VMIN [NV] = '{3, 2, 1, 0, 0};
    localparam int VMAX [NV] = '{3, 4, 5, 6, 6};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] mod_idx = 8'd0;
    logic [5:0] gate_up, gate_dn;
    logic [2:0] ins_cnt;

    always #10 clk = ~clk;

    lspwm_arm #(
        .NSM(NSM), .CW(CW), .PW(8), .MW(8),
        .CAR_DIV(CAR_DIV), .PH_DIV(PH_DIV), .ROT_DIV(ROT_DIV), .DT_CYC(DT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .mod_idx(mod_idx),
        .gate_up(gate_up), .gate_dn(gate_dn), .ins_cnt(ins_cnt)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit win = 1'b0;
    bit m0_mode = 1'b0;

    // monitor state, owned by the monitor process
    int cyc = 0;
    int prev_cnt = 0;
    int stable_run = 0;
    int cmin = 99, cmax = -1;
    int agree_err = 0, shoot_err = 0, dt_err = 0, range_err = 0, m0_err = 0;
    int offrun [NSM];
    logic [5:0] prev_up = '0, prev_dn = '0;
    int npat = 0;
    logic [5:0] pat_log [16];
    int pat_t [16];
    bit have_last = 1'b0;
    logic [5:0] last_pat = '0;

    function automatic logic [5:0] exp_pat(input int r);
        logic [5:0] p;
        for (int i = 0; i < NSM; i++) begin
            p[i] = ((i + r) % NSM) < (NSM / 2);
        end
        return p;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        bit settled;
        cyc++;
        settled = ((gate_up ^ gate_dn) == 6'h3f);
        if (rst_n) begin
            if ((gate_up & gate_dn) != 6'h00) shoot_err++;
            if (int'(ins_cnt) > NSM) range_err++;
            for (int i = 0; i < NSM; i++) begin
                if ((gate_up[i] && !prev_up[i]) || (gate_dn[i] && !prev_dn[i])) begin
                    if (offrun[i] < DT) dt_err++;
                end
                if (!gate_up[i] && !gate_dn[i]) offrun[i]++;
                else offrun[i] = 0;
            end
            if (int'(ins_cnt) == prev_cnt) stable_run++;
            else stable_run = 0;
            if (en && stable_run >= DT + 3 && settled &&
                $countones(gate_up) != int'(ins_cnt)) agree_err++;
            if (win) begin
                if (int'(ins_cnt) < cmin) cmin = int'(ins_cnt);
                if (int'(ins_cnt) > cmax) cmax = int'(ins_cnt);
            end else begin
                cmin = 99;
                cmax = -1;
            end
            if (!en) begin
                have_last = 1'b0;
                npat = 0;
            end else if (settled && (!have_last || gate_up != last_pat)) begin
                if (npat < 16) begin
                    pat_log[npat] = gate_up;
                    pat_t[npat]   = cyc;
                end
                npat++;
                last_pat  = gate_up;
                have_last = 1'b1;
            end
            if (m0_mode && en && settled && ins_cnt != 3'd3) m0_err++;
        end else begin
            for (int i = 0; i < NSM; i++) offrun[i] = 0;
        end
        prev_up  = gate_up;
        prev_dn  = gate_dn;
        prev_cnt = int'(ins_cnt);
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(gate_up == 0 && gate_dn == 0, "R1 gates in reset", int'({gate_up, gate_dn}), 0);
        chk(ins_cnt == 0, "R1 count in reset", int'(ins_cnt), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(gate_up == 0 && gate_dn == 0 && ins_cnt == 0, "R1 idle while en low",
            int'({gate_up, gate_dn}), 0);

        // rotation run with zero index
        mod_idx = 8'd0;
        m0_mode = 1'b1;
        en = 1'b1;
        repeat (10000) @(negedge clk);
        #1;
        chk(npat >= 8, "R8 number of rotations seen", npat, 8);
        chk(pat_log[0] == exp_pat(0), "R1 first pattern after enable",
            int'(pat_log[0]), int'(exp_pat(0)));
        for (int n = 1; n < 8; n++) begin
            chk(pat_log[n] == exp_pat(n), "R8 pattern after rotation",
                int'(pat_log[n]), int'(exp_pat(n)));
        end
        for (int n = 2; n < 8; n++) begin
            chk(pat_t[n] - pat_t[n-1] == ROT_GAP, "R9 rotation spacing",
                pat_t[n] - pat_t[n-1], ROT_GAP);
        end
        chk(m0_err == 0, "R2 count fixed at 3 for zero index", m0_err, 0);

        // disable then re-enable: rotation index cleared
        en = 1'b0;
        @(negedge clk);
        chk(gate_up == 0 && gate_dn == 0 && ins_cnt == 0, "R1 off after disable",
            int'({gate_up, gate_dn}), 0);
        en = 1'b1;
        repeat (50) @(negedge clk);
        #1;
        chk(npat >= 1 && pat_log[0] == exp_pat(0), "R1 rotation restarts at zero",
            int'(pat_log[0]), int'(exp_pat(0)));
        m0_mode = 1'b0;

        // index sweep over a full fundamental period each
        for (int v = 0; v < NV; v++) begin
            int a0;
            string rq;
            rq = (VM[v] == 0) ? "R2" : ((VM[v] == 255) ? "R3" : "R4");
            a0 = agree_err;
            mod_idx = 8'(VM[v]);
            repeat (300) @(negedge clk);
            win = 1'b1;
            repeat (FUND + PERIOD) @(negedge clk);
            #1;
            chk(cmin == VMIN[v], {rq, " minimum count"}, cmin, VMIN[v]);
            chk(cmax == VMAX[v], {rq, " maximum count"}, cmax, VMAX[v]);
            chk(agree_err == a0, "R5 upper gates match count", agree_err - a0, 0);
            win = 1'b0;
        end

        chk(shoot_err == 0, "R6 both gates on", shoot_err, 0);
        chk(dt_err == 0, "R7 dead time shortened", dt_err, 0);
        chk(range_err == 0, "R2 count above 6", range_err, 0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule